// File: doc/BRIEF.md
# PASID-Granular Translation Context Walker

This block finds the translation context for one DMA request when the remapping unit resolves every request per process address space rather than per requester. A request carries a 16-bit requester ID and, optionally, a 20-bit PASID. The walker first reads the requester's context entry from a flat table at a 4 KiB-aligned root base. If the request has no PASID of its own, it takes a substitute PASID stored in that context entry. It then splits the PASID in two. The upper 14 bits select an entry in a PASID directory. The lower 6 bits select an entry in the leaf table that the directory entry points to. The leaf entry gives the first-level and second-level page-table roots and the enabled levels.

All three reads go through a single memory read port, one at a time. The caller sees one result pulse. It carries either a translation mode with both table roots, or a fault code that names the level where the walk stopped. The walker never runs ahead of its memory port: it has exactly one lookup and one memory read in flight.

The control is a state machine with these states:
- ST_IDLE: accepts a request.
- ST_CTX_RD, ST_DIR_RD, ST_LEAF_RD: present one read on the memory port until it is taken.
- ST_CTX_WT, ST_DIR_WT, ST_LEAF_WT: wait for the matching response.
- ST_DONE: raises the result for one cycle.

The transitions are:
- ST_IDLE to ST_CTX_RD on req_valid.
- Each *_RD state to its *_WT state on mem_req_ready.
- ST_CTX_WT to ST_DIR_RD, and ST_DIR_WT to ST_LEAF_RD, on a response whose present bit is set.
- ST_CTX_WT or ST_DIR_WT to ST_DONE on a response whose present bit is clear.
- ST_LEAF_WT to ST_DONE on any response.
- ST_DONE to ST_IDLE always.

Top module: `pasid_ctx_walker`

## Requirements
- R1: req_ready is high only while the walker is idle. It falls in the cycle after a request is accepted and rises again in the cycle after the one-cycle res_valid pulse.
- R2: The context entry is read at root_base (low 12 bits ignored) + requester ID × 8. In that entry, bit 0 is present, bits [12 +: ADDR_W-12] hold the directory page number, and bits [63:44] hold the substitute PASID.
- R3: The directory entry is read at (directory page << 12) + PASID[19:6] × 8. In that entry, bit 0 is present and bits [12 +: ADDR_W-12] hold the leaf-table page number.
- R4: The leaf entry is read at (leaf page << 12) + PASID[5:0] × 8. In that entry, bit 0 is present, bit 1 enables the first level, bit 2 enables the second level, bits [12 +: ADDR_W-12] hold the first-level page number, and bits [44 +: ADDR_W-12] hold the second-level page number.
- R5: A request with req_has_pasid low ignores req_pasid and walks with the substitute PASID from its context entry. res_pasid reports the PASID that was used.
- R6: Reads are issued in the order context, directory, leaf, with at most one outstanding read. A read that is not yet accepted keeps mem_req_valid high and its address stable.
- R7: A clear present bit ends the walk with no further reads. The fault code is 1 for the context entry, 2 for the directory entry and 3 for the leaf entry.
- R8: res_mode is 3 (nested) when both levels are enabled, 1 when only the first level is enabled, and 2 when only the second level is enabled. res_fl_ptr and res_sl_ptr carry the enabled levels' page numbers shifted left by 12, and zero for a disabled level.
- R9: A leaf entry fails with fault code 4 if it enables a level whose capability input is low, or if it enables no level. On any fault, res_mode and both pointers are zero.
- R10: After reset, req_ready is 1 and res_valid and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | ADDR_W | Context table base, 4 KiB aligned |
| cap_fl | input | 1 | First-level translation supported |
| cap_sl | input | 1 | Second-level translation supported |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_rid | input | RID_W | Requester ID (bus/device/function) |
| req_has_pasid | input | 1 | Request carries its own PASID |
| req_pasid | input | PASID_W | Request PASID |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 3 | 0 none, 1 context, 2 directory, 3 leaf, 4 mode |
| res_pasid | output | PASID_W | PASID used for the walk |
| res_fl_ptr | output | ADDR_W | First-level table root |
| res_sl_ptr | output | ADDR_W | Second-level table root |
| res_mode | output | 2 | 1 first only, 2 second only, 3 nested |

## Verification
Assertions check the port protocol on every cycle:
- req_ready drops after acceptance and res_valid lasts exactly one cycle;
- a pending memory read holds its address, and no read is issued while idle or while a response is due;
- a fault never comes with a mode, and a successful mode never uses a level whose capability is off.

Only the bench scenarios can show that the three addresses are formed from the right PASID fields, that the substitute PASID replaces the request's PASID, that the walk stops at the failing level, and that the returned pointers match the leaf entry. The bench shows this by sweeping directory and leaf indices against every pairing of enabled levels and capability inputs.

// File: rtl/pctx_pkg.sv
package pctx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTX_RD,
        ST_CTX_WT,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_LEAF_RD,
        ST_LEAF_WT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_CTX  = 3'd1,
        FLT_DIR  = 3'd2,
        FLT_LEAF = 3'd3,
        FLT_MODE = 3'd4
    } walk_fault_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_FIRST  = 2'd1,
        MODE_SECOND = 2'd2,
        MODE_NESTED = 2'd3
    } xlat_mode_e;

    // Entry field positions shared by all three tables
    localparam int PRESENT_BIT  = 0;
    localparam int FL_EN_BIT    = 1;
    localparam int SL_EN_BIT    = 2;
    localparam int PAGE_LSB     = 12;
    localparam int HIGH_FLD_LSB = 44;

endpackage

// File: rtl/pctx_addr.sv
// Forms the byte address of an entry: page-aligned base plus index times entry size.
module pctx_addr #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 16,
    parameter int ENT_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        page_base = {base_i[ADDR_W-1:12], 12'b0};
        offset    = {{PAD_W{1'b0}}, idx_i} << ENT_LOG2;
        addr_o    = page_base + offset;
    end
endmodule

// File: rtl/pctx_leaf_decode.sv
// Turns a leaf PASID entry and the capability inputs into a mode or a fault.
module pctx_leaf_decode
    import pctx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [63:0]       entry_i,
    input  logic              cap_fl_i,
    input  logic              cap_sl_i,
    output walk_fault_e       fault_o,
    output xlat_mode_e        mode_o,
    output logic [ADDR_W-1:0] fl_ptr_o,
    output logic [ADDR_W-1:0] sl_ptr_o
);
    localparam int PG_W = ADDR_W - 12;

    logic fl_en;
    logic sl_en;
    logic bad_level;

    always_comb begin
        fl_en     = entry_i[FL_EN_BIT];
        sl_en     = entry_i[SL_EN_BIT];
        bad_level = (!fl_en && !sl_en) || (fl_en && !cap_fl_i) || (sl_en && !cap_sl_i);
        fault_o   = FLT_NONE;
        mode_o    = MODE_OFF;
        fl_ptr_o  = '0;
        sl_ptr_o  = '0;
        if (!entry_i[PRESENT_BIT]) begin
            fault_o = FLT_LEAF;
        end else if (bad_level) begin
            fault_o = FLT_MODE;
        end else begin
            mode_o = xlat_mode_e'({sl_en, fl_en});
            if (fl_en) fl_ptr_o = {entry_i[PAGE_LSB +: PG_W], 12'b0};
            if (sl_en) sl_ptr_o = {entry_i[HIGH_FLD_LSB +: PG_W], 12'b0};
        end
    end
endmodule

// File: rtl/pasid_ctx_walker.sv
module pasid_ctx_walker
    import pctx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RID_W      = 16,
    parameter int PASID_W    = 20,
    parameter int LEAF_IDX_W = 6,
    parameter int ENT_LOG2   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  root_base,
    input  logic               cap_fl,
    input  logic               cap_sl,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [RID_W-1:0]   req_rid,
    input  logic               req_has_pasid,
    input  logic [PASID_W-1:0] req_pasid,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_data,
    output logic               res_valid,
    output logic [2:0]         res_fault,
    output logic [PASID_W-1:0] res_pasid,
    output logic [ADDR_W-1:0]  res_fl_ptr,
    output logic [ADDR_W-1:0]  res_sl_ptr,
    output logic [1:0]         res_mode
);
    localparam int DIR_IDX_W = PASID_W - LEAF_IDX_W;
    localparam int PG_W      = ADDR_W - 12;
    localparam int IDX_W     = (RID_W > DIR_IDX_W) ? RID_W : DIR_IDX_W;

    walk_state_e       state_q, state_d;
    logic [RID_W-1:0]  rid_q;
    logic              has_pasid_q;
    logic [PASID_W-1:0] pasid_q;
    logic [PG_W-1:0]   dir_pg_q;
    logic [PG_W-1:0]   leaf_pg_q;
    walk_fault_e       fault_q;
    xlat_mode_e        mode_q;
    logic [ADDR_W-1:0] fl_q;
    logic [ADDR_W-1:0] sl_q;

    logic [ADDR_W-1:0] tbl_base;
    logic [IDX_W-1:0]  tbl_idx;
    logic              entry_present;

    walk_fault_e       dec_fault;
    xlat_mode_e        dec_mode;
    logic [ADDR_W-1:0] dec_fl;
    logic [ADDR_W-1:0] dec_sl;

    assign entry_present = mem_rsp_data[PRESENT_BIT];

    // Table base and index for the level being read
    always_comb begin
        tbl_base = root_base;
        tbl_idx  = IDX_W'(rid_q);
        unique case (state_q)
            ST_DIR_RD: begin
                tbl_base = {dir_pg_q, 12'b0};
                tbl_idx  = IDX_W'(pasid_q[PASID_W-1:LEAF_IDX_W]);
            end
            ST_LEAF_RD: begin
                tbl_base = {leaf_pg_q, 12'b0};
                tbl_idx  = IDX_W'(pasid_q[LEAF_IDX_W-1:0]);
            end
            default: begin
                tbl_base = root_base;
                tbl_idx  = IDX_W'(rid_q);
            end
        endcase
    end

    pctx_addr #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .ENT_LOG2(ENT_LOG2)
    ) i_addr (
        .base_i(tbl_base),
        .idx_i (tbl_idx),
        .addr_o(mem_req_addr)
    );

    pctx_leaf_decode #(
        .ADDR_W(ADDR_W)
    ) i_leaf_dec (
        .entry_i (mem_rsp_data),
        .cap_fl_i(cap_fl),
        .cap_sl_i(cap_sl),
        .fault_o (dec_fault),
        .mode_o  (dec_mode),
        .fl_ptr_o(dec_fl),
        .sl_ptr_o(dec_sl)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_CTX_RD;
            ST_CTX_RD:  if (mem_req_ready) state_d = ST_CTX_WT;
            ST_CTX_WT:  if (mem_rsp_valid) state_d = entry_present ? ST_DIR_RD : ST_DONE;
            ST_DIR_RD:  if (mem_req_ready) state_d = ST_DIR_WT;
            ST_DIR_WT:  if (mem_rsp_valid) state_d = entry_present ? ST_LEAF_RD : ST_DONE;
            ST_LEAF_RD: if (mem_req_ready) state_d = ST_LEAF_WT;
            ST_LEAF_WT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_CTX_RD) || (state_q == ST_DIR_RD) ||
                        (state_q == ST_LEAF_RD);
        res_valid     = (state_q == ST_DONE);
        res_fault     = fault_q;
        res_mode      = mode_q;
        res_pasid     = pasid_q;
        res_fl_ptr    = fl_q;
        res_sl_ptr    = sl_q;
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rid_q       <= '0;
            has_pasid_q <= 1'b0;
            pasid_q     <= '0;
            dir_pg_q    <= '0;
            leaf_pg_q   <= '0;
            fault_q     <= FLT_NONE;
            mode_q      <= MODE_OFF;
            fl_q        <= '0;
            sl_q        <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    rid_q       <= req_rid;
                    has_pasid_q <= req_has_pasid;
                    pasid_q     <= req_pasid;
                    fault_q     <= FLT_NONE;
                    mode_q      <= MODE_OFF;
                    fl_q        <= '0;
                    sl_q        <= '0;
                end
                ST_CTX_WT: if (mem_rsp_valid) begin
                    if (entry_present) begin
                        dir_pg_q <= mem_rsp_data[PAGE_LSB +: PG_W];
                        if (!has_pasid_q) pasid_q <= mem_rsp_data[HIGH_FLD_LSB +: PASID_W];
                    end else begin
                        fault_q <= FLT_CTX;
                    end
                end
                ST_DIR_WT: if (mem_rsp_valid) begin
                    if (entry_present) leaf_pg_q <= mem_rsp_data[PAGE_LSB +: PG_W];
                    else               fault_q   <= FLT_DIR;
                end
                ST_LEAF_WT: if (mem_rsp_valid) begin
                    fault_q <= dec_fault;
                    mode_q  <= dec_mode;
                    fl_q    <= dec_fl;
                    sl_q    <= dec_sl;
                end
                default: ;
            endcase
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R1
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && req_ready); // R1
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid); // R6
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R6
    AST_FAULT_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault != 3'd0 |-> res_mode == 2'd0 && res_fl_ptr == '0 && res_sl_ptr == '0); // R9
    AST_MODE_WITHIN_CAPS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault == 3'd0 |->
            res_mode != 2'd0 && (!res_mode[0] || cap_fl) && (!res_mode[1] || cap_sl)); // R9

endmodule

// File: tb/test_pasid_ctx_walker.sv
`timescale 1ns/1ps
module test_pasid_ctx_walker;

    localparam int ADDR_W = 32;
    localparam logic [31:0] ROOT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = ROOT;
    logic        cap_fl = 1'b1;
    logic        cap_sl = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_rid = '0;
    logic        req_has_pasid = 1'b0;
    logic [19:0] req_pasid = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [2:0]  res_fault;
    logic [19:0] res_pasid;
    logic [31:0] res_fl_ptr;
    logic [31:0] res_sl_ptr;
    logic [1:0]  res_mode;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] mem [logic [31:0]];
    logic [31:0] rd_log[$];

    always #2 clk = ~clk;

    pasid_ctx_walker i_pasid_ctx_walker (
        .clk(clk), .rst_n(rst_n), .root_base(root_base), .cap_fl(cap_fl), .cap_sl(cap_sl),
        .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid),
        .req_has_pasid(req_has_pasid), .req_pasid(req_pasid),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_pasid(res_pasid), .res_fl_ptr(res_fl_ptr), .res_sl_ptr(res_sl_ptr),
        .res_mode(res_mode)
    );

    // Sparse memory: stalls one cycle in three, answers one cycle after acceptance
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 2;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
            rd_log.push_back(mem_req_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ctx_ent(input logic [19:0] dpg, input logic [19:0] rp);
        return 64'd1 | ({44'd0, dpg} << 12) | ({44'd0, rp} << 44);
    endfunction

    function automatic logic [63:0] dir_ent(input logic [19:0] lpg);
        return 64'd1 | ({44'd0, lpg} << 12);
    endfunction

    function automatic logic [63:0] leaf_ent(input bit fe, input bit se,
                                             input logic [19:0] fpg, input logic [19:0] spg);
        return 64'd1 | (64'(fe) << 1) | (64'(se) << 2) | ({44'd0, fpg} << 12) | ({44'd0, spg} << 44);
    endfunction

    task automatic lookup(input logic [15:0] rid, input bit has, input logic [19:0] pasid,
                          input logic [2:0] e_fault, input logic [1:0] e_mode,
                          input logic [31:0] e_fl, input logic [31:0] e_sl,
                          input logic [19:0] e_pasid, input int n_rd,
                          input logic [31:0] a0, input logic [31:0] a1, input logic [31:0] a2);
        bit busy_ok = 1'b1;
        bit done = 1'b0;
        logic [31:0] exp_a [3];
        exp_a[0] = a0; exp_a[1] = a1; exp_a[2] = a2;
        @(negedge clk);
        rd_log.delete();
        req_valid = 1'b1; req_rid = rid; req_has_pasid = has; req_pasid = pasid;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 200; w++) begin
            if (res_valid) begin done = 1'b1; break; end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        chk(done, "R1", "result delivered", done, 1);
        chk(busy_ok, "R1", "ready low while busy", busy_ok, 1);
        chk(res_fault == e_fault, "R7", "fault code", res_fault, e_fault);
        chk(res_mode == e_mode, "R8", "mode", res_mode, e_mode);
        chk(res_fl_ptr == e_fl, "R8", "first-level root", res_fl_ptr, e_fl);
        chk(res_sl_ptr == e_sl, "R8", "second-level root", res_sl_ptr, e_sl);
        if (e_fault == 3'd0 || e_fault == 3'd4)
            chk(res_pasid == e_pasid, "R5", "pasid used", res_pasid, e_pasid);
        chk(rd_log.size() == n_rd, "R6", "read count", rd_log.size(), n_rd);
        for (int k = 0; k < n_rd && k < rd_log.size(); k++)
            chk(rd_log[k] == exp_a[k], (k == 0) ? "R2" : (k == 1) ? "R3" : "R4",
                "read address", rd_log[k], exp_a[k]);
        @(negedge clk);
        chk(!res_valid && req_ready, "R1", "pulse ended and ready back",
            {res_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [19:0] his [3];
        logic [5:0]  los [3];
        his[0] = 20'h0; his[1] = 20'h5; his[2] = 20'h3FFF;
        los[0] = 6'd0;  los[1] = 6'd33; los[2] = 6'd63;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
        chk(res_valid == 1'b0, "R10", "res_valid in reset", res_valid, 0);
        chk(mem_req_valid == 1'b0, "R10", "mem_req_valid in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_req_valid, "R10", "idle after reset",
            {req_ready, res_valid, mem_req_valid}, 3'b100);

        // Sweep: directory index, leaf index, enabled levels, capabilities (R3 R4 R8 R9)
        mem[ROOT + 32'h0123 * 8] = ctx_ent(20'h00100, 20'h0);
        foreach (his[i]) begin
            mem[32'h0010_0000 + his[i] * 8] = dir_ent(20'h00200 + his[i]);
            foreach (los[j]) begin
                for (int m = 0; m < 4; m++) begin
                    for (int c = 0; c < 4; c++) begin
                        logic [19:0] pas;
                        logic [31:0] la;
                        logic [19:0] fpg;
                        logic [19:0] spg;
                        bit bad;
                        pas = (his[i] << 6) | 20'(los[j]);
                        la  = ((32'h00200 + 32'(his[i])) << 12) + 32'(los[j]) * 8;
                        fpg = 20'h0A000 | 20'(los[j]);
                        spg = 20'h0B000 | 20'(los[j]);
                        mem[la] = leaf_ent(m[0], m[1], fpg, spg);
                        cap_fl = c[0]; cap_sl = c[1];
                        bad = (m == 0) || (m[0] && !c[0]) || (m[1] && !c[1]);
                        lookup(16'h0123, 1'b1, pas,
                               bad ? 3'd4 : 3'd0, bad ? 2'd0 : 2'(m),
                               (!bad && m[0]) ? {fpg, 12'h0} : 32'h0,
                               (!bad && m[1]) ? {spg, 12'h0} : 32'h0,
                               pas, 3, ROOT + 32'h0123 * 8,
                               32'h0010_0000 + 32'(his[i]) * 8, la);
                    end
                end
            end
        end

        // R5: substitute PASID 0x12345 -> directory index 0x48D, leaf index 5
        cap_fl = 1'b1; cap_sl = 1'b1;
        mem[ROOT + 32'h0456 * 8] = ctx_ent(20'h00300, 20'h12345);
        mem[32'h0030_0000 + 32'h48D * 8] = dir_ent(20'h00350);
        mem[32'h0035_0000 + 32'd5 * 8] = leaf_ent(1'b1, 1'b1, 20'h11111, 20'h22222);
        lookup(16'h0456, 1'b0, 20'hFFFFF, 3'd0, 2'd3, 32'h1111_1000, 32'h2222_2000,
               20'h12345, 3, ROOT + 32'h0456 * 8, 32'h0030_0000 + 32'h48D * 8,
               32'h0035_0000 + 32'd5 * 8);
        lookup(16'h0456, 1'b1, 20'h12345, 3'd0, 2'd3, 32'h1111_1000, 32'h2222_2000,
               20'h12345, 3, ROOT + 32'h0456 * 8, 32'h0030_0000 + 32'h48D * 8,
               32'h0035_0000 + 32'd5 * 8);

        // R7: each fault level stops the walk
        lookup(16'h0777, 1'b1, 20'h00001, 3'd1, 2'd0, 32'h0, 32'h0, 20'h0, 1,
               ROOT + 32'h0777 * 8, 32'h0, 32'h0);
        lookup(16'h0456, 1'b1, 20'h00001, 3'd2, 2'd0, 32'h0, 32'h0, 20'h0, 2,
               ROOT + 32'h0456 * 8, 32'h0030_0000, 32'h0);
        lookup(16'h0456, 1'b1, 20'h12346, 3'd3, 2'd0, 32'h0, 32'h0, 20'h0, 3,
               ROOT + 32'h0456 * 8, 32'h0030_0000 + 32'h48D * 8, 32'h0035_0000 + 32'd6 * 8);

        // R2: root base low bits are ignored
        root_base = ROOT | 32'h0000_0ABC;
        lookup(16'h0456, 1'b0, 20'h0, 3'd0, 2'd3, 32'h1111_1000, 32'h2222_2000,
               20'h12345, 3, ROOT + 32'h0456 * 8, 32'h0030_0000 + 32'h48D * 8,
               32'h0035_0000 + 32'd5 * 8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule